// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block governs a port of 32 I/O lines from a 32-bit register bus, where bit n of every register stands for line n. Each line is either owned by the port itself as a general-purpose I/O, with its own output value and drive enable, or handed to one of four peripheral functions. When a line is handed to a function, that function's output value and drive enable reach the pad. Configuration state is changed through paired set and clear addresses, so software never needs a read-modify-write sequence.

On top of the basic mux, a line can be put in multi-drive mode. In that mode it behaves as an open-drain line: it pulls low and releases the pad for a high value. A single masked write can update the output value of many lines at once. The raw pad level can be read at any time. Pull-up and pull-down requests are held per line and never coexist. A peripheral can freeze a line's configuration, and a keyed write-protect switch can freeze all configuration and record any attempt that it blocks.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the line-ownership register reads all ones (every line a GPIO), and the direction, output value, multi-drive, pull-up, pull-down, sync-mask and function-select registers, the protect switch and the violation flag all read zero; no pad is driven.
- R2: Each paired register is changed only in the bits written as 1. Writing to its set word (offset +0) sets those bits and writing to its clear word (offset +1) clears them. Its status word (offset +2) reads the state. The bases are: ownership 0x00, direction 0x04, output value 0x08, multi-drive 0x0C, pull-up 0x10, pull-down 0x14, sync mask 0x18.
- R3: A line whose ownership bit is 1 drives pad_out from its output-value bit and pad_oe from its direction bit.
- R4: A line whose ownership bit is 0 takes its function number f = {plane1[n], plane0[n]}, with plane k written and read at 0x1C+k. It drives pad_out from per_out[f*32+n] and pad_oe from per_oe[f*32+n].
- R5: A line in multi-drive mode always presents pad_out 0. Its pad_oe is 1 only when its selected source requests drive with a low value.
- R6: A write to 0x0B loads the output-value bits whose sync-mask bit is 1 from the write data and leaves every other output-value bit unchanged.
- R7: Word 0x20 reads pad_in for every line, whatever its ownership or mode.
- R8: Setting pull-up bits clears the same pull-down bits, and setting pull-down bits clears the same pull-up bits. pad_pu and pad_pd show the two registers, and they are never both 1 on a line.
- R9: While per_lock[n] is 1, writes leave bit n of the ownership, direction, multi-drive, pull-up, pull-down and function-select registers unchanged.
- R10: A write to 0x24 changes the protect switch to wdata[0] only when wdata[31:8] equals the key 0x5EC0DE; any other write there is ignored. Word 0x24 reads the switch in bit 0.
- R11: While the protect switch is 1, writes to the configuration words (0x00-0x01, 0x04-0x05, 0x0C-0x0D, 0x10-0x11, 0x14-0x15, 0x18-0x19, 0x1C-0x1D) are dropped and set the violation flag, read in bit 0 of 0x25. Output-value writes still take effect, and a keyed write to 0x24 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for a write access |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Level seen on each pad |
| pad_out | output | 32 | Value presented to each pad |
| pad_oe | output | 32 | Pad drive enable |
| pad_pu | output | 32 | Pull-up request per line |
| pad_pd | output | 32 | Pull-down request per line |
| per_out | input | 128 | Output value of function f for line n at bit f*32+n |
| per_oe | input | 128 | Drive enable of function f for line n at bit f*32+n |
| per_lock | input | 32 | Peripheral lock per line |

## Verification
The bench targets the mixing corners. A multi-drive line with a high value must float; a design that passes the value through would fight the bus. A masked sync write must spare unmasked lines; a design that ignores the mask would corrupt them. The pull pair must stay exclusive, and a design that misses the cross-clear would leave both pulls on. Locked and protected lines are also covered: a design that leaks a write through a lock or a protected window shows a changed status word, and a flag that does not latch or is never cleared reads back wrong. Random traffic with random locks, pad levels and function outputs is compared against a behavioural model every clock.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int N = 32,
  parameter int NF = 4,
  parameter logic [23:0] WP_KEY = 24'h5EC0DE,
  parameter logic [N-1:0] OWN_RST = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [7:0]      bus_addr,
  input  logic [N-1:0]    bus_wdata,
  output logic [N-1:0]    bus_rdata,
  input  logic [N-1:0]    pad_in,
  output logic [N-1:0]    pad_out,
  output logic [N-1:0]    pad_oe,
  output logic [N-1:0]    pad_pu,
  output logic [N-1:0]    pad_pd,
  input  logic [NF*N-1:0] per_out,
  input  logic [NF*N-1:0] per_oe,
  input  logic [N-1:0]    per_lock
);
  localparam int SELW = (NF > 1) ? $clog2(NF) : 1;
  localparam logic [7:0] A_OWN = 8'h00, A_DIR = 8'h04, A_VAL = 8'h08, A_SYNC = 8'h0B;
  localparam logic [7:0] A_MD = 8'h0C, A_PU = 8'h10, A_PD = 8'h14, A_MSK = 8'h18;
  localparam logic [7:0] A_SEL = 8'h1C, A_PIN = 8'h20, A_WP = 8'h24, A_VIO = 8'h25;

  logic [N-1:0] own_q, dir_q, dout_q, md_q, pu_q, pd_q, owm_q;
  logic [N-1:0] sel_q [SELW];
  logic wp_en, viol;

  wire wr = bus_sel & bus_we;
  wire [5:0] wbase = bus_addr[7:2];
  wire wlo = ~bus_addr[1];
  wire is_cfg = wlo & ((bus_addr[7:2] <= 6'h7) & (bus_addr[7:2] != 6'h2));
  wire blocked = wr & wp_en & is_cfg;
  wire cfg_wr = wr & ~wp_en;
  wire wset = ~bus_addr[0];
  wire [N-1:0] wb = bus_wdata & ~per_lock;
  wire key_ok = bus_wdata[N-1 -: 24] == WP_KEY;

  function automatic logic [N-1:0] setclr(input logic [N-1:0] cur, input logic [N-1:0] b, input logic s);
    return s ? (cur | b) : (cur & ~b);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= OWN_RST;
      dir_q <= '0;
      md_q  <= '0;
      pu_q  <= '0;
      pd_q  <= '0;
      owm_q <= '0;
    end else if (cfg_wr && wlo) begin
      if (wbase == A_OWN[7:2]) own_q <= setclr(own_q, wb, wset);
      if (wbase == A_DIR[7:2]) dir_q <= setclr(dir_q, wb, wset);
      if (wbase == A_MD[7:2])  md_q  <= setclr(md_q, wb, wset);
      if (wbase == A_MSK[7:2]) owm_q <= setclr(owm_q, bus_wdata, wset);
      if (wbase == A_PU[7:2]) begin
        pu_q <= setclr(pu_q, wb, wset);
        if (wset) pd_q <= pd_q & ~wb;
      end
      if (wbase == A_PD[7:2]) begin
        pd_q <= setclr(pd_q, wb, wset);
        if (wset) pu_q <= pu_q & ~wb;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dout_q <= '0;
    else if (wr && bus_addr == A_SYNC) dout_q <= (dout_q & ~owm_q) | (bus_wdata & owm_q);
    else if (wr && wbase == A_VAL[7:2] && wlo) dout_q <= setclr(dout_q, bus_wdata, wset);
  end

  for (genvar k = 0; k < SELW; k++) begin : g_plane
    always_ff @(posedge clk) begin
      if (!rst_n) sel_q[k] <= '0;
      else if (cfg_wr && bus_addr == A_SEL + 8'(k)) sel_q[k] <= (sel_q[k] & per_lock) | wb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_en <= 1'b0;
      viol  <= 1'b0;
    end else if (wr && bus_addr == A_WP && key_ok) begin
      wp_en <= bus_wdata[0];
      viol  <= 1'b0;
    end else if (blocked) begin
      viol  <= 1'b1;
    end
  end

  always_comb begin
    for (int n = 0; n < N; n++) begin
      int f;
      logic o, e;
      f = 0;
      for (int k = 0; k < SELW; k++) f = f | (int'(sel_q[k][n]) << k);
      o = own_q[n] ? dout_q[n] : per_out[f*N+n];
      e = own_q[n] ? dir_q[n]  : per_oe[f*N+n];
      pad_out[n] = md_q[n] ? 1'b0 : o;
      pad_oe[n]  = md_q[n] ? (e & ~o) : e;
    end
  end

  assign pad_pu = pu_q;
  assign pad_pd = pd_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_OWN + 8'd2: bus_rdata = own_q;
      A_DIR + 8'd2: bus_rdata = dir_q;
      A_VAL + 8'd2: bus_rdata = dout_q;
      A_MD  + 8'd2: bus_rdata = md_q;
      A_PU  + 8'd2: bus_rdata = pu_q;
      A_PD  + 8'd2: bus_rdata = pd_q;
      A_MSK + 8'd2: bus_rdata = owm_q;
      A_PIN:        bus_rdata = pad_in;
      A_WP:         bus_rdata = {{(N-1){1'b0}}, wp_en};
      A_VIO:        bus_rdata = {{(N-1){1'b0}}, viol};
      default:      bus_rdata = '0;
    endcase
    for (int k = 0; k < SELW; k++)
      if (bus_addr == A_SEL + 8'(k)) bus_rdata = sel_q[k];
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(parameter int N = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_we,
  input logic [7:0]   bus_addr,
  input logic [N-1:0] per_lock,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] md_q,
  input logic [N-1:0] pu_q,
  input logic [N-1:0] pd_q,
  input logic [N-1:0] dir_q,
  input logic [N-1:0] dout_q,
  input logic [N-1:0] owm_q,
  input logic         wp_en,
  input logic         viol
);
  p_open_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (md_q & pad_out) == '0);

  p_pull_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_q & pd_q) == '0);

  p_lock_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dir_q ^ $past(dir_q)) & $past(per_lock)) == '0);

  p_sync_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 8'h0B) |=> ((dout_q ^ $past(dout_q)) & ~$past(owm_q)) == '0);

  p_wp_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && wp_en && bus_addr == 8'h04) |=> ($stable(dir_q) && viol));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .per_lock(per_lock), .pad_out(pad_out), .md_q(md_q), .pu_q(pu_q), .pd_q(pd_q),
  .dir_q(dir_q), .dout_q(dout_q), .owm_q(owm_q), .wp_en(wp_en), .viol(viol)
);

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] KEY = 24'h5EC0DE;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] pad_in = 0, pad_out, pad_oe, pad_pu, pad_pd;
  logic [127:0] per_out = 0, per_oe = 0;
  logic [31:0] per_lock = 0;

  int checks = 0, errors = 0;
  bit live = 0;

  logic [31:0] m_own, m_dir, m_val, m_md, m_pu, m_pd, m_msk, m_s0, m_s1;
  bit m_wp, m_vio;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .per_out(per_out), .per_oe(per_oe), .per_lock(per_lock));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdl_reset();
    m_own = '1; m_dir = 0; m_val = 0; m_md = 0; m_pu = 0; m_pd = 0;
    m_msk = 0; m_s0 = 0; m_s1 = 0; m_wp = 0; m_vio = 0;
  endtask

  task automatic mdl_write(input logic [7:0] a, input logic [31:0] d, input logic [31:0] lk);
    bit prot;
    logic [31:0] b;
    prot = a inside {8'h00, 8'h01, 8'h04, 8'h05, 8'h0C, 8'h0D, 8'h10, 8'h11,
                     8'h14, 8'h15, 8'h18, 8'h19, 8'h1C, 8'h1D};
    b = d & ~lk;
    if (a == 8'h24) begin
      if (d[31:8] == KEY) begin m_wp = d[0]; m_vio = 0; end
    end else if (prot && m_wp) begin
      m_vio = 1;
    end else begin
      case (a)
        8'h00: m_own |= b;   8'h01: m_own &= ~b;
        8'h04: m_dir |= b;   8'h05: m_dir &= ~b;
        8'h08: m_val |= d;   8'h09: m_val &= ~d;
        8'h0B: m_val = (m_val & ~m_msk) | (d & m_msk);
        8'h0C: m_md |= b;    8'h0D: m_md &= ~b;
        8'h10: begin m_pu |= b; m_pd &= ~b; end
        8'h11: m_pu &= ~b;
        8'h14: begin m_pd |= b; m_pu &= ~b; end
        8'h15: m_pd &= ~b;
        8'h18: m_msk |= d;   8'h19: m_msk &= ~d;
        8'h1C: m_s0 = (m_s0 & lk) | b;
        8'h1D: m_s1 = (m_s1 & lk) | b;
        default: ;
      endcase
    end
  endtask

  // Every clock: compare pad outputs with the behavioural model (R3 R4 R5 R8)
  always @(posedge clk) begin
    #3;
    if (live) begin
      logic [31:0] eo, ee;
      for (int n = 0; n < 32; n++) begin
        int f;
        logic o, e;
        f = {m_s1[n], m_s0[n]};
        o = m_own[n] ? m_val[n] : per_out[f*32+n];
        e = m_own[n] ? m_dir[n] : per_oe[f*32+n];
        eo[n] = m_md[n] ? 1'b0 : o;
        ee[n] = m_md[n] ? (e & ~o) : e;
      end
      chk("R3/R4/R5 pad_out", pad_out, eo);
      chk("R3/R4/R5 pad_oe", pad_oe, ee);
      chk("R8 pad_pu", pad_pu, m_pu);
      chk("R8 pad_pd", pad_pd, m_pd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; mdl_write(a, d, per_lock);
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #2; chk(req, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic pads(input logic [31:0] m, input logic [31:0] o, input logic [31:0] e, input string req);
    @(negedge clk); #1;
    chk({req, " out"}, pad_out & m, o);
    chk({req, " oe"}, pad_oe & m, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    // R1 reset state
    rd(8'h02, 32'hFFFF_FFFF, "R1 ownership");
    rd(8'h06, 32'h0, "R1 direction");
    rd(8'h24, 32'h0, "R1 protect");
    rd(8'h25, 32'h0, "R1 violation");
    pads('1, 32'h0, 32'h0, "R1 pads");
    // R2 set/clear
    wr(8'h04, 32'hFF); wr(8'h05, 32'h0F);
    rd(8'h06, 32'hF0, "R2 direction");
    wr(8'h08, 32'hF0F0); wr(8'h09, 32'h3000);
    rd(8'h0A, 32'hC0F0, "R2 output value");
    // R3 GPIO drive
    pads(32'hFF, 32'hF0, 32'hF0, "R3 gpio");
    // R4 function mux
    per_out = {32'h0000_5500, 32'h0000_AA00, 32'hFFFF_FFFF, 32'h0};
    per_oe = '1;
    wr(8'h01, 32'h0000_FF00);
    wr(8'h1C, 32'h0000_F000);
    wr(8'h1D, 32'h0000_CC00);
    rd(8'h1D, 32'h0000_CC00, "R4 plane1");
    pads(32'h0000_FF00, 32'h0000_7800, 32'h0000_FF00, "R4 mux");
    // R5 open drain
    wr(8'h0C, 32'hC0);
    pads(32'hC0, 32'h0, 32'h0, "R5 release high");
    wr(8'h09, 32'h40);
    pads(32'hC0, 32'h0, 32'h40, "R5 drive low");
    // R6 masked sync write
    wr(8'h18, 32'h0000_FFFF);
    wr(8'h0B, 32'hAAAA_AAAA);
    rd(8'h0A, 32'h0000_AAAA, "R6 sync write");
    // R7 pin level
    pad_in = 32'h1234_5678;
    rd(8'h20, 32'h1234_5678, "R7 pin level");
    // R8 pulls
    wr(8'h10, 32'hF); wr(8'h14, 32'h3);
    rd(8'h12, 32'hC, "R8 pull-up");
    rd(8'h16, 32'h3, "R8 pull-down");
    // R9 lock
    per_lock = 32'h1;
    wr(8'h04, 32'h3);
    rd(8'h06, 32'hF2, "R9 locked direction");
    wr(8'h15, 32'h3);
    rd(8'h16, 32'h1, "R9 locked pull-down");
    per_lock = 0;
    // R10 key
    wr(8'h24, {24'h123456, 8'h01});
    rd(8'h24, 32'h0, "R10 wrong key");
    wr(8'h24, {KEY, 8'h01});
    rd(8'h24, 32'h1, "R10 right key");
    // R11 protection
    wr(8'h04, 32'h100);
    rd(8'h06, 32'hF2, "R11 blocked direction");
    rd(8'h25, 32'h1, "R11 violation set");
    wr(8'h08, 32'h1);
    rd(8'h0A, 32'h0000_AAAB, "R11 value unprotected");
    wr(8'h24, {KEY, 8'h00});
    rd(8'h25, 32'h0, "R11 violation cleared");
    wr(8'h04, 32'h100);
    rd(8'h06, 32'h1F2, "R11 unprotected again");
    // Random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [7:0] alist [18] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h08, 8'h09, 8'h0B, 8'h0C, 8'h0D,
                                 8'h10, 8'h11, 8'h14, 8'h15, 8'h18, 8'h19, 8'h1C, 8'h1D, 8'h24};
      @(negedge clk);
      pad_in = $urandom;
      per_lock = ($urandom % 4 == 0) ? $urandom : 32'h0;
      per_out = {$urandom, $urandom, $urandom, $urandom};
      per_oe = {$urandom, $urandom, $urandom, $urandom};
      a = alist[$urandom % 18];
      if (a == 8'h24) wr(a, {($urandom % 2) ? KEY : 24'h0, 7'h0, 1'($urandom)});
      else wr(a, $urandom);
      if (i % 8 == 0) rd(8'h20, pad_in, "R7 random pin");
      if (i % 8 == 4) rd(8'h0A, m_val, "R2 random value");
      if (i % 8 == 6) rd(8'h25, {31'h0, m_vio}, "R11 random violation");
    end
    live = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule